// File: doc/BRIEF.md
# CAS-Latency Read Data Sequencer

This block decides, cycle by cycle, when a DRAM-style device drives read data. It also decides which beats of the burst go out. A command stream enters on a small opcode port: activate, read, write, burst stop, precharge, or idle. On each rising clock edge the block registers one beat pair for the data bus. The pair is an even beat for the first half of the clock and an odd beat for the second half. It comes with a bus-enable flag and the tag of the read that owns the data. A device model uses the pair to fetch words from its storage. A controller-side checker uses it as the expected read timeline.

Read data starts a fixed number of clocks after the read. That number is the CAS latency, which may be 3, 4 or 5. A burst stop or precharge ends the data only after the same latency. A newer read takes over the bus exactly one latency after it is issued. A read or write that carries the auto-precharge flag produces a one-clock internal precharge pulse. The pulse waits for the burst to complete and for the minimum active time since the last activate. The block also raises a flag while a write would still collide with outstanding read data.

Top module: `rd_beat_sequencer`

## Requirements
- R1: While reset is asserted, and after its release until the first command, `dq_oe`, `ap_start` and `wr_block` are 0.
- R2: A read sampled at edge k with `cas_lat` = L (3, 4 or 5) makes `dq_oe` rise at edge k+L, with beat pair (0,1).
- R3: A burst covers BL/2 clocks of beat pairs (0,1),(2,3),..., where `cmd_blc` codes 0, 1, 2 and 3 select BL = 2, 4, 8 and 8.
- R4: A read sampled while an earlier burst is pending or running leaves the earlier beats unchanged up to edge k+L-1. From edge k+L it restarts at pair (0,1) with its own tag, for its own full length.
- R5: A burst stop (opcode 4) sampled at edge s makes `dq_oe` low from edge s+L.
- R6: A precharge (opcode 5) sampled at edge s makes `dq_oe` low from edge s+L and cancels any pending auto-precharge.
- R7: When a stop takes effect on the same edge as the natural end of a burst, no extra beat pair appears.
- R8: A read with `cmd_ap`=1 sampled at edge k pulses `ap_start` for one clock at edge max(k+BL/2, a+TRAS), where a is the edge of the last activate (opcode 1).
- R9: A write (opcode 3) with `cmd_ap`=1 sampled at edge k pulses `ap_start` at edge max(k+BL/2+TWR, a+TRAS).
- R10: A read or write without `cmd_ap`, sampled before a pending pulse fires, cancels that pulse.
- R11: After a read at edge k, `wr_block` stays high until a write could first be sampled at edge k+L+BL/2+1.
- R12: Activate, write and idle opcodes (0, 1, 3) never change `dq_oe`, the beat indices or the tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_op | input | 3 | Opcode: 0 idle, 1 activate, 2 read, 3 write, 4 burst stop, 5 precharge |
| cmd_ap | input | 1 | Auto-precharge request with a read or write |
| cmd_blc | input | 2 | Burst length code: 0 gives 2, 1 gives 4, 2 or 3 gives 8 |
| cmd_tag | input | TAG_W | Identifier of the read, returned with its beats |
| cas_lat | input | 3 | CAS latency in clocks, 3 to 5 |
| dq_oe | output | 1 | Data bus driven during this clock |
| beat_even | output | 3 | Beat index for the first half clock |
| beat_odd | output | 3 | Beat index for the second half clock |
| beat_tag | output | TAG_W | Tag of the read that owns the current beats |
| ap_start | output | 1 | One-clock internal precharge start pulse |
| wr_block | output | 1 | A write sampled at the next edge would be too early |

## Verification
The assertions assume the environment keeps `cas_lat` between 3 and 5. They also assume it holds the latency steady while any read, stop or precharge event is still travelling through the latency line. Both are checked as properties on the inputs. They further assume that no write is issued while `wr_block` is high. The stimulus changes the latency only after a long idle gap, and spaces every write well beyond the read-to-write window. Interrupting reads, stops and precharges are placed only where the command rules allow them.

// File: rtl/rbs_pkg.sv
package rbs_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int unsigned MAX_BL = 8;
  localparam int unsigned CNT_W  = $clog2(MAX_BL) + 1;

  typedef enum logic [2:0] {
    OP_NOP   = 3'd0,
    OP_ACT   = 3'd1,
    OP_READ  = 3'd2,
    OP_WRITE = 3'd3,
    OP_BSTOP = 3'd4,
    OP_PRE   = 3'd5
  } op_e;

  typedef enum logic [1:0] {
    EV_NONE  = 2'd0,
    EV_START = 2'd1,
    EV_STOP  = 2'd2
  } ev_kind_e;

  typedef struct packed {
    ev_kind_e   kind;
    logic [1:0] blc;
  } lat_ev_t;

  function automatic logic [CNT_W-1:0] beats_of(input logic [1:0] blc);
    case (blc)
      2'd0:    beats_of = CNT_W'(2);
      2'd1:    beats_of = CNT_W'(4);
      default: beats_of = CNT_W'(MAX_BL);
    endcase
  endfunction
endpackage

// File: rtl/rbs_lat_line.sv
module rbs_lat_line
  import rbs_pkg::*;
#(
  parameter int unsigned MAX_CL = 5,
  parameter int unsigned TAG_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  lat_ev_t          ev_in,
  input  logic [TAG_W-1:0] tag_in,
  input  logic [2:0]       cas_lat,
  output lat_ev_t          ev_tap,
  output logic [TAG_W-1:0] tag_tap
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int unsigned SEL_W = $clog2(MAX_CL);

  lat_ev_t          st_q [MAX_CL];
  lat_ev_t          st_d [MAX_CL];
  logic [TAG_W-1:0] tg_q [MAX_CL];
  logic [TAG_W-1:0] tg_d [MAX_CL];
  logic [SEL_W-1:0] sel;
  logic             any_pend;

  for (genvar i = 0; i < MAX_CL; i++) begin : g_stage
    if (i == 0) begin : g_head
      assign st_d[i] = ev_in;
      assign tg_d[i] = tag_in;
    end else begin : g_body
      assign st_d[i] = st_q[i-1];
      assign tg_d[i] = tg_q[i-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_q[i] <= '{kind: EV_NONE, blc: 2'd0};
        tg_q[i] <= '0;
      end else begin
        st_q[i] <= st_d[i];
        tg_q[i] <= tg_d[i];
      end
    end
  end

  // Stage j holds an event j+1 edges after capture; the consumer registers
  // it on the next edge, so latency L reads stage L-1.
  always_comb begin
    int unsigned t;
    t = 32'(cas_lat);
    if (t < 2) t = 2;
    if (t > MAX_CL) t = MAX_CL;
    sel = SEL_W'(t - 1);
  end

  assign ev_tap  = st_q[sel];
  assign tag_tap = tg_q[sel];

  always_comb begin
    any_pend = 1'b0;
    for (int i = 0; i < MAX_CL; i++) begin
      if (st_q[i].kind != EV_NONE) any_pend = 1'b1;
    end
  end

  AST_CL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (cas_lat >= 3'd3) && (32'(cas_lat) <= MAX_CL)); // R2
  AST_CL_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    any_pend |-> $stable(cas_lat)); // R2
endmodule

// File: rtl/rbs_beat_gen.sv
module rbs_beat_gen
  import rbs_pkg::*;
#(
  parameter int unsigned TAG_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  lat_ev_t          ev_tap,
  input  logic [TAG_W-1:0] tag_tap,
  output logic             dq_oe,
  output logic [2:0]       beat_even,
  output logic [2:0]       beat_odd,
  output logic [TAG_W-1:0] beat_tag
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int unsigned IDX_W = CNT_W - 1;

  logic             act_q, act_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] len_q, len_d;
  logic [CNT_W-1:0] nxt;
  logic [TAG_W-1:0] tag_q, tag_d;
  logic             en;

  always_comb begin
    act_d = act_q;
    cnt_d = cnt_q;
    len_d = len_q;
    tag_d = tag_q;
    nxt   = cnt_q + CNT_W'(2);
    if (act_q) begin
      if (nxt >= len_q) begin
        act_d = 1'b0;
        cnt_d = '0;
      end else begin
        cnt_d = nxt;
      end
    end
    // A stop that lands with the natural end changes nothing further.
    if (ev_tap.kind == EV_STOP) begin
      act_d = 1'b0;
      cnt_d = '0;
    end
    // A new burst overrides whatever remains of the old one.
    if (ev_tap.kind == EV_START) begin
      act_d = 1'b1;
      cnt_d = '0;
      len_d = beats_of(ev_tap.blc);
      tag_d = tag_tap;
    end
  end

  assign en = act_q | (ev_tap.kind != EV_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      cnt_q <= '0;
      len_q <= '0;
      tag_q <= '0;
    end else if (en) begin
      act_q <= act_d;
      cnt_q <= cnt_d;
      len_q <= len_d;
      tag_q <= tag_d;
    end
  end

  assign dq_oe     = act_q;
  assign beat_even = cnt_q[IDX_W-1:0];
  assign beat_odd  = cnt_q[IDX_W-1:0] | IDX_W'(1);
  assign beat_tag  = tag_q;

  AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> (cnt_q + CNT_W'(2) <= len_q)); // R3
  AST_PAIR_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe && $past(dq_oe) && ($past(ev_tap.kind) == EV_NONE))
      |-> (cnt_q == $past(cnt_q) + CNT_W'(2))); // R3
  AST_START_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_tap.kind == EV_START) |=> (dq_oe && (beat_even == 3'd0)
      && (beat_tag == $past(tag_tap)))); // R4
  AST_TERM_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_tap.kind == EV_STOP) |=> !dq_oe); // R5
  AST_NO_EXTRA_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe && (cnt_q + CNT_W'(2) == len_q) && (ev_tap.kind != EV_START))
      |=> !dq_oe); // R7
endmodule

// File: rtl/rbs_ap_timer.sv
module rbs_ap_timer
  import rbs_pkg::*;
#(
  parameter int unsigned TRAS = 6,
  parameter int unsigned TWR  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       is_act,
  input  logic       is_rd,
  input  logic       is_wr,
  input  logic       is_pre,
  input  logic       cmd_ap,
  input  logic [1:0] cmd_blc,
  output logic       ap_start
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int unsigned AP_MAX = MAX_BL / 2 + TWR;
  localparam int unsigned AP_W   = $clog2(AP_MAX + 1);
  localparam int unsigned RAS_W  = $clog2(TRAS + 1);

  logic             pend_q, pend_d;
  logic [AP_W-1:0]  cnt_q, cnt_d;
  logic [RAS_W-1:0] ras_q, ras_d;
  logic             pulse_q, pulse_d;
  logic [CNT_W-1:0] half;
  logic             en;

  assign half = beats_of(cmd_blc) >> 1;

  always_comb begin
    ras_d   = (ras_q != '0) ? ras_q - RAS_W'(1) : '0;
    cnt_d   = (cnt_q != '0) ? cnt_q - AP_W'(1) : '0;
    pend_d  = pend_q;
    pulse_d = 1'b0;
    if (is_act) ras_d = RAS_W'(TRAS - 1);
    // Due once both the burst window and the active-time window are over.
    if (pend_q && (cnt_q == '0) && (ras_q == '0)) begin
      pulse_d = 1'b1;
      pend_d  = 1'b0;
    end
    if (is_rd || is_wr) begin
      pend_d = cmd_ap;
      cnt_d  = is_rd ? AP_W'(half) - AP_W'(1)
                     : AP_W'(half) + AP_W'(TWR) - AP_W'(1);
    end
    if (is_pre) pend_d = 1'b0;
  end

  assign en = is_act | is_rd | is_wr | is_pre | pend_q | pulse_q | (ras_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      cnt_q   <= '0;
      ras_q   <= '0;
      pulse_q <= 1'b0;
    end else if (en) begin
      pend_q  <= pend_d;
      cnt_q   <= cnt_d;
      ras_q   <= ras_d;
      pulse_q <= pulse_d;
    end
  end

  assign ap_start = pulse_q;

  AST_AP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    ap_start |=> !ap_start); // R8
  AST_PRE_CANCELS: assert property (@(posedge clk) disable iff (!rst_n)
    is_pre |-> ##2 !ap_start); // R6
  AST_PLAIN_CANCELS: assert property (@(posedge clk) disable iff (!rst_n)
    ((is_rd || is_wr) && !cmd_ap) |-> ##2 !ap_start); // R10
endmodule

// File: rtl/rbs_turn_guard.sv
module rbs_turn_guard
  import rbs_pkg::*;
#(
  parameter int unsigned MAX_CL = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       is_rd,
  input  logic       is_wr,
  input  logic [2:0] cas_lat,
  input  logic [1:0] cmd_blc,
  output logic       wr_block
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int unsigned GAP_MAX = MAX_CL + MAX_BL / 2;
  localparam int unsigned GAP_W   = $clog2(GAP_MAX + 1);

  logic [GAP_W-1:0] gap_q, gap_d;
  logic             en;

  always_comb begin
    if (is_rd) gap_d = GAP_W'(cas_lat) + GAP_W'(beats_of(cmd_blc) >> 1);
    else       gap_d = (gap_q != '0) ? gap_q - GAP_W'(1) : '0;
  end

  assign en = is_rd | (gap_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  gap_q <= '0;
    else if (en) gap_q <= gap_d;
  end

  assign wr_block = (gap_q != '0);

  AST_WR_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    is_wr |-> !wr_block); // R11
  AST_GAP_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    is_rd |=> wr_block); // R11
endmodule

// File: rtl/rd_beat_sequencer.sv
module rd_beat_sequencer
  import rbs_pkg::*;
#(
  parameter int unsigned TAG_W  = 4,
  parameter int unsigned MAX_CL = 5,
  parameter int unsigned TRAS   = 6,
  parameter int unsigned TWR    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       cmd_op,
  input  logic             cmd_ap,
  input  logic [1:0]       cmd_blc,
  input  logic [TAG_W-1:0] cmd_tag,
  input  logic [2:0]       cas_lat,
  output logic             dq_oe,
  output logic [2:0]       beat_even,
  output logic [2:0]       beat_odd,
  output logic [TAG_W-1:0] beat_tag,
  output logic             ap_start,
  output logic             wr_block
);
  timeunit 1ns;
  timeprecision 1ps;

  op_e              op;
  logic             is_act, is_rd, is_wr, is_stop, is_pre;
  lat_ev_t          ev_in, ev_tap;
  logic [TAG_W-1:0] tag_tap;

  assign op      = op_e'(cmd_op);
  assign is_act  = (op == OP_ACT);
  assign is_rd   = (op == OP_READ);
  assign is_wr   = (op == OP_WRITE);
  assign is_stop = (op == OP_BSTOP);
  assign is_pre  = (op == OP_PRE);

  always_comb begin
    ev_in.kind = EV_NONE;
    ev_in.blc  = cmd_blc;
    if (is_rd)                  ev_in.kind = EV_START;
    else if (is_stop || is_pre) ev_in.kind = EV_STOP;
  end

  rbs_lat_line #(.MAX_CL(MAX_CL), .TAG_W(TAG_W)) u_lat_line (
    .clk     (clk),
    .rst_n   (rst_n),
    .ev_in   (ev_in),
    .tag_in  (cmd_tag),
    .cas_lat (cas_lat),
    .ev_tap  (ev_tap),
    .tag_tap (tag_tap)
  );

  rbs_beat_gen #(.TAG_W(TAG_W)) u_beat_gen (
    .clk       (clk),
    .rst_n     (rst_n),
    .ev_tap    (ev_tap),
    .tag_tap   (tag_tap),
    .dq_oe     (dq_oe),
    .beat_even (beat_even),
    .beat_odd  (beat_odd),
    .beat_tag  (beat_tag)
  );

  rbs_ap_timer #(.TRAS(TRAS), .TWR(TWR)) u_ap_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .is_act   (is_act),
    .is_rd    (is_rd),
    .is_wr    (is_wr),
    .is_pre   (is_pre),
    .cmd_ap   (cmd_ap),
    .cmd_blc  (cmd_blc),
    .ap_start (ap_start)
  );

  rbs_turn_guard #(.MAX_CL(MAX_CL)) u_turn_guard (
    .clk      (clk),
    .rst_n    (rst_n),
    .is_rd    (is_rd),
    .is_wr    (is_wr),
    .cas_lat  (cas_lat),
    .cmd_blc  (cmd_blc),
    .wr_block (wr_block)
  );

  AST_NO_BEATS_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dq_oe) |-> (beat_even == 3'd0)); // R2
endmodule

// File: tb/rd_beat_sequencer_bench.sv
module rd_beat_sequencer_bench;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int TAG_W = 4;
  localparam int TRAS  = 6;
  localparam int TWR   = 2;
  localparam int SZ    = 4096;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [2:0]       cmd_op = 3'd0;
  logic             cmd_ap = 1'b0;
  logic [1:0]       cmd_blc = 2'd0;
  logic [TAG_W-1:0] cmd_tag = '0;
  logic [2:0]       cas_lat = 3'd3;
  logic             dq_oe, ap_start, wr_block;
  logic [2:0]       beat_even, beat_odd;
  logic [TAG_W-1:0] beat_tag;

  always #2.5 clk = ~clk;

  rd_beat_sequencer #(.TAG_W(TAG_W), .MAX_CL(5), .TRAS(TRAS), .TWR(TWR)) u_rd_beat_sequencer (
    .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .cmd_ap(cmd_ap), .cmd_blc(cmd_blc),
    .cmd_tag(cmd_tag), .cas_lat(cas_lat), .dq_oe(dq_oe), .beat_even(beat_even),
    .beat_odd(beat_odd), .beat_tag(beat_tag), .ap_start(ap_start), .wr_block(wr_block)
  );

  int    cyc = 0;
  bit    exp_oe   [SZ];
  int    exp_even [SZ];
  int    exp_tag  [SZ];
  int    ap_q[$];
  int    act_e = -100;
  int    rd_ok = 0;
  int    vectors = 0;
  int    fails = 0;
  bit    done = 1'b0;
  string cur_req = "R1";

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  task automatic check(input string req, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s at edge %0d: actual=%0d expected=%0d", req, what, cyc, act, exp);
    end
  endtask

  function automatic int beats(input int blc);
    if (blc == 0) return 2;
    if (blc == 1) return 4;
    return 8;
  endfunction

  task automatic clear_from(input int c);
    for (int i = c; i < SZ; i++) exp_oe[i] = 1'b0;
  endtask

  task automatic cancel_after(input int k);
    while (ap_q.size() > 0 && ap_q[$] > k) void'(ap_q.pop_back());
  endtask

  // Driver: drives one command for the next edge and records what it must cause.
  task automatic issue(input int op, input bit ap, input int tag, input int blc);
    int k, cl, bl, due;
    @(negedge clk);
    k  = cyc + 1;
    cl = int'(cas_lat);
    bl = beats(blc);
    cmd_op  = 3'(op);
    cmd_ap  = ap;
    cmd_tag = TAG_W'(tag);
    cmd_blc = 2'(blc);
    case (op)
      1: act_e = k;
      2: begin
        clear_from(k + cl);
        for (int j = 0; j < bl / 2; j++) begin
          exp_oe[k + cl + j]   = 1'b1;
          exp_even[k + cl + j] = 2 * j;
          exp_tag[k + cl + j]  = tag;
        end
        rd_ok = k + cl + bl / 2 + 1;
        cancel_after(k);
        if (ap) begin
          due = k + bl / 2;
          if (act_e + TRAS > due) due = act_e + TRAS;
          ap_q.push_back(due);
        end
      end
      3: begin
        cancel_after(k);
        if (ap) begin
          due = k + bl / 2 + TWR;
          if (act_e + TRAS > due) due = act_e + TRAS;
          ap_q.push_back(due);
        end
      end
      4: clear_from(k + cl);
      5: begin
        clear_from(k + cl);
        cancel_after(k);
      end
      default: ;
    endcase
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      cmd_op = 3'd0;
      cmd_ap = 1'b0;
    end
  endtask

  task automatic set_cl(input int v);
    @(negedge clk);
    cmd_op  = 3'd0;
    cmd_ap  = 1'b0;
    cas_lat = 3'(v);
  endtask

  // Monitor: compares the scoreboard against the outputs of each edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (rst_n && !done) begin
        int e;
        e = cyc;
        check(cur_req, "dq_oe", int'(dq_oe), int'(exp_oe[e]));
        if (dq_oe && exp_oe[e]) begin
          check(cur_req, "beat_even", int'(beat_even), exp_even[e]);
          check(cur_req, "beat_odd", int'(beat_odd), exp_even[e] + 1);
          check(cur_req, "beat_tag", int'(beat_tag), exp_tag[e]);
        end
        check("R11", "wr_block", int'(wr_block), int'(e + 1 < rd_ok));
        if (ap_start) begin
          if (ap_q.size() == 0) check(cur_req, "unexpected ap_start", 1, 0);
          else check(cur_req, "ap_start edge", e, ap_q.pop_front());
        end else if (ap_q.size() > 0 && ap_q[0] < e) begin
          check(cur_req, "missing ap_start", -1, ap_q.pop_front());
        end
      end
    end
  end

  initial begin
    #100000;
    if (!done) begin
      vectors++;
      fails++;
      $display("FAIL R1 watchdog: actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    check("R1", "dq_oe in reset", int'(dq_oe), 0);
    check("R1", "ap_start in reset", int'(ap_start), 0);
    check("R1", "wr_block in reset", int'(wr_block), 0);
    @(negedge clk);
    rst_n = 1'b1;
    cur_req = "R1";
    idle(3);

    cur_req = "R12";
    issue(1, 0, 0, 0);
    idle(2);
    issue(3, 0, 9, 1);
    idle(8);

    cur_req = "R2";
    issue(2, 0, 1, 1);
    idle(10);
    set_cl(4);
    issue(2, 0, 2, 2);
    idle(12);
    set_cl(5);
    issue(2, 0, 3, 0);
    idle(12);

    cur_req = "R3";
    set_cl(3);
    issue(2, 0, 4, 2);
    idle(12);
    issue(2, 0, 5, 3);
    idle(12);

    cur_req = "R4";
    issue(2, 0, 6, 2);
    idle(1);
    issue(2, 0, 7, 1);
    idle(12);
    issue(2, 0, 8, 2);
    issue(2, 0, 9, 0);
    idle(12);

    cur_req = "R5";
    issue(2, 0, 10, 2);
    issue(4, 0, 0, 0);
    idle(12);
    set_cl(5);
    issue(2, 0, 11, 2);
    idle(2);
    issue(4, 0, 0, 0);
    idle(14);
    set_cl(3);

    cur_req = "R6";
    issue(2, 0, 12, 2);
    idle(1);
    issue(5, 0, 0, 0);
    idle(12);

    cur_req = "R7";
    issue(2, 0, 13, 1);
    idle(1);
    issue(4, 0, 0, 0);
    idle(10);

    cur_req = "R8";
    issue(1, 0, 0, 0);
    issue(2, 1, 14, 0);
    idle(12);
    issue(1, 0, 0, 0);
    idle(10);
    issue(2, 1, 15, 2);
    idle(12);

    cur_req = "R9";
    issue(3, 1, 0, 1);
    idle(12);
    issue(1, 0, 0, 0);
    issue(3, 1, 0, 0);
    idle(12);

    cur_req = "R10";
    issue(2, 1, 1, 2);
    issue(2, 0, 2, 2);
    idle(14);
    issue(3, 1, 0, 2);
    issue(3, 0, 0, 2);
    idle(12);

    cur_req = "R6";
    issue(1, 0, 0, 0);
    idle(8);
    issue(2, 1, 3, 2);
    idle(1);
    issue(5, 0, 0, 0);
    idle(14);

    done = 1'b1;
    if (ap_q.size() != 0) check("R8", "ap pulses left unseen", ap_q.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule